// File: doc/BRIEF.md
# ADC Window Alarm with Hysteresis

This block sits behind a converter's result path and watches three monitored channels: two external inputs and one temperature channel. Each conversion result arrives as a one-cycle strobe carrying a channel number and a 12-bit code. The result is compared with that channel's own window. Each window is set by an 8-bit upper byte and an 8-bit lower byte. A channel enters fault only after a programmable run of consecutive out-of-window results. It leaves fault only when a later result sits inside the window by a programmable margin of codes.

For each channel the block reports a fault flag and a 2-bit action code taken from configuration. It also drives one combined alarm request, the OR of all fault flags whose mask bit is clear. The fault flags always show the true state, whatever the mask. Sequencing the converter and carrying out the action are done elsewhere.

Top module: `adc_window_alarm`

## Requirements
- R1: The upper limit of channel i is the 12-bit value {thr_hi byte i, 4'b1111}. A result strictly above it counts as a violation. A result equal to it does not.
- R2: The lower limit of channel i is the 12-bit value {thr_lo byte i, 4'b0000}. A result strictly below it counts as a violation. A result equal to it does not.
- R3: During reset and after its release, fault_flag, fault_act and alarm_irq are all zero. With thr_hi = FFh and thr_lo = 00h, no 12-bit result can set a flag.
- R4: With run_limit = N, fault_flag[i] sets on the clock edge that samples the (N+1)-th consecutive violating result of channel i. The flag is visible one cycle after that strobe.
- R5: A non-violating result of channel i clears that channel's run count. Results of other channels leave the count unchanged.
- R6: A channel in fault clears on a result that meets two conditions: result + hyst <= upper limit, and result >= lower limit + hyst. The arithmetic uses 13 bits, so with a small upper limit and a large hyst the flag cannot clear.
- R7: A channel in fault keeps its flag on any result that fails the R6 condition. This includes results inside the window but within hyst codes of a limit.
- R8: fault_act slice i equals act_cfg slice i while fault_flag[i] is set and mask[i] is 0. Otherwise it is 0 (no action). The codes are: 0 = none, 1 = force clear state, 2 = drive alarm voltage, 3 = output high impedance.
- R9: alarm_irq is 1 exactly when some channel has fault_flag set and mask bit 0. A mask bit of 1 hides that channel from alarm_irq but leaves its fault_flag unchanged.
- R10: A strobe whose res_chan is NCH or higher changes no channel's flag or count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_valid | input | 1 | One-cycle strobe, conversion result present |
| res_chan | input | 2 | Channel number of the result (0..2 valid) |
| res_data | input | 12 | Conversion code |
| thr_hi | input | 24 | Upper limit byte per channel, channel i at [8i+7:8i] |
| thr_lo | input | 24 | Lower limit byte per channel, channel i at [8i+7:8i] |
| hyst | input | 7 | Hysteresis in codes applied when leaving fault |
| run_limit | input | 3 | Consecutive violations needed, minus one |
| mask | input | 3 | Per-channel alarm mask, 1 blocks |
| act_cfg | input | 6 | Per-channel action code, channel i at [2i+1:2i] |
| fault_flag | output | 3 | Per-channel fault state |
| fault_act | output | 6 | Per-channel action in force, 0 when idle or masked |
| alarm_irq | output | 1 | OR of unmasked fault flags |

## Verification
The bench places results exactly on each limit and one code past it. A design that used >= or <= would trip on the boundary code, and one that dropped the fixed low nibble would move the limit by 15 codes. Results inside the hysteresis band test that a flagged channel clears at neither too small nor too large a margin. A very small upper limit with a large hysteresis tests that the clear condition does not wrap around. Violations interleaved with another channel's in-window results, together with one in-window reset of the run, catch a counter that is shared between channels or never cleared. A strobe on the unused channel number 3 catches decoding that aliases onto a real channel.

// File: rtl/adc_win_pkg.sv
package adc_win_pkg;
  localparam int ACT_W = 2;

  typedef enum logic [ACT_W-1:0] {
    ACT_NONE  = 2'd0,
    ACT_CLEAR = 2'd1,
    ACT_ALMV  = 2'd2,
    ACT_HIZ   = 2'd3
  } fault_act_e;
endpackage

// File: rtl/adc_win_compare.sv
module adc_win_compare #(
  parameter int DW = 12,
  parameter int TW = 8,
  parameter int HW = 7
) (
  input  logic [DW-1:0] data,
  input  logic [TW-1:0] lim_hi,
  input  logic [TW-1:0] lim_lo,
  input  logic [HW-1:0] hyst,
  output logic          violate,
  output logic          release_ok
);
  localparam int PADW = DW - TW;

  logic [DW-1:0] hi_full;
  logic [DW-1:0] lo_full;
  logic [DW:0]   data_x;
  logic [DW:0]   hyst_x;

  always_comb begin
    hi_full    = {lim_hi, {PADW{1'b1}}};
    lo_full    = {lim_lo, {PADW{1'b0}}};
    data_x     = {1'b0, data};
    hyst_x     = (DW+1)'(hyst);
    violate    = (data > hi_full) || (data < lo_full);
    release_ok = ((data_x + hyst_x) <= {1'b0, hi_full}) &&
                 (data_x >= ({1'b0, lo_full} + hyst_x));
  end
endmodule

// File: rtl/adc_win_chan.sv
module adc_win_chan #(
  parameter int DW = 12,
  parameter int TW = 8,
  parameter int HW = 7,
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit,
  input  logic [DW-1:0] data,
  input  logic [TW-1:0] lim_hi,
  input  logic [TW-1:0] lim_lo,
  input  logic [HW-1:0] hyst,
  input  logic [CW-1:0] run_limit,
  output logic          flag
);
  logic          violate;
  logic          release_ok;
  logic [CW-1:0] run_q, run_d;
  logic          flag_q, flag_d;
  logic          upd;

  adc_win_compare #(.DW(DW), .TW(TW), .HW(HW)) u_cmp (
    .data       (data),
    .lim_hi     (lim_hi),
    .lim_lo     (lim_lo),
    .hyst       (hyst),
    .violate    (violate),
    .release_ok (release_ok)
  );

  always_comb begin
    upd    = hit;
    run_d  = run_q;
    flag_d = flag_q;
    if (flag_q) begin
      run_d = '0;
      if (release_ok) flag_d = 1'b0;
    end else if (!violate) begin
      run_d = '0;
    end else if (run_q == run_limit) begin
      run_d  = '0;
      flag_d = 1'b1;
    end else begin
      run_d = run_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      flag_q <= 1'b0;
    end else if (upd) begin
      run_q  <= run_d;
      flag_q <= flag_d;
    end
  end

  assign flag = flag_q;
endmodule

// File: rtl/adc_window_alarm.sv
module adc_window_alarm
  import adc_win_pkg::*;
#(
  parameter int NCH = 3,
  parameter int DW  = 12,
  parameter int TW  = 8,
  parameter int HW  = 7,
  parameter int CW  = 3,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 res_valid,
  input  logic [CHW-1:0]       res_chan,
  input  logic [DW-1:0]        res_data,
  input  logic [NCH*TW-1:0]    thr_hi,
  input  logic [NCH*TW-1:0]    thr_lo,
  input  logic [HW-1:0]        hyst,
  input  logic [CW-1:0]        run_limit,
  input  logic [NCH-1:0]       mask,
  input  logic [NCH*ACT_W-1:0] act_cfg,
  output logic [NCH-1:0]       fault_flag,
  output logic [NCH*ACT_W-1:0] fault_act,
  output logic                 alarm_irq
);
  logic [NCH-1:0] live;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic hit;
    assign hit = res_valid && (res_chan == CHW'(i));

    adc_win_chan #(.DW(DW), .TW(TW), .HW(HW), .CW(CW)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .hit       (hit),
      .data      (res_data),
      .lim_hi    (thr_hi[i*TW +: TW]),
      .lim_lo    (thr_lo[i*TW +: TW]),
      .hyst      (hyst),
      .run_limit (run_limit),
      .flag      (fault_flag[i])
    );

    assign live[i] = fault_flag[i] & ~mask[i];
    assign fault_act[i*ACT_W +: ACT_W] =
      live[i] ? act_cfg[i*ACT_W +: ACT_W] : ACT_NONE;
  end

  assign alarm_irq = |live;
endmodule

// File: rtl/adc_window_alarm_chk.sv
module adc_window_alarm_chk
  import adc_win_pkg::*;
#(
  parameter int NCH = 3,
  parameter int DW  = 12,
  parameter int TW  = 8,
  parameter int HW  = 7,
  parameter int CW  = 3,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 res_valid,
  input logic [CHW-1:0]       res_chan,
  input logic [DW-1:0]        res_data,
  input logic [NCH*TW-1:0]    thr_hi,
  input logic [NCH*TW-1:0]    thr_lo,
  input logic [HW-1:0]        hyst,
  input logic [CW-1:0]        run_limit,
  input logic [NCH-1:0]       mask,
  input logic [NCH*ACT_W-1:0] act_cfg,
  input logic [NCH-1:0]       fault_flag,
  input logic [NCH*ACT_W-1:0] fault_act,
  input logic                 alarm_irq
);
  localparam int PADW = DW - TW;

  for (genvar i = 0; i < NCH; i++) begin : g_p
    // R4: a flag can only rise on an edge that sampled a strobe for this channel
    p_rise_needs_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fault_flag[i]) |-> $past(res_valid && (int'(res_chan) == i)));

    // R1 and R2: the sample that tripped the flag lay outside the window
    p_rise_outside_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fault_flag[i]) |->
        $past((res_data > {thr_hi[i*TW +: TW], {PADW{1'b1}}}) ||
              (res_data < {thr_lo[i*TW +: TW], {PADW{1'b0}}})));

    // R6: leaving fault also requires a strobe for this channel
    p_fall_needs_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(fault_flag[i]) |-> $past(res_valid && (int'(res_chan) == i)));

    // R8: no action is driven for an idle channel
    p_act_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !fault_flag[i] |-> (fault_act[i*ACT_W +: ACT_W] == ACT_NONE));
  end

  // R9: the request only appears with an unmasked fault behind it
  p_irq_backed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_irq |-> ((fault_flag & ~mask) != '0));

  // R10: edges without a valid channel strobe leave every flag alone
  p_ignore_bad_chan_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!res_valid || (int'(res_chan) >= NCH)) |=> $stable(fault_flag));
endmodule

bind adc_window_alarm adc_window_alarm_chk #(
  .NCH(NCH), .DW(DW), .TW(TW), .HW(HW), .CW(CW)
) u_chk (.*);

// File: tb/tb_adc_window_alarm.sv
module tb_adc_window_alarm;
  localparam int NCH = 3;

  logic        clk;
  logic        rst_n;
  logic        res_valid;
  logic [1:0]  res_chan;
  logic [11:0] res_data;
  logic [23:0] thr_hi;
  logic [23:0] thr_lo;
  logic [6:0]  hyst;
  logic [2:0]  run_limit;
  logic [2:0]  mask;
  logic [5:0]  act_cfg;
  logic [2:0]  fault_flag;
  logic [5:0]  fault_act;
  logic        alarm_irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  adc_window_alarm dut (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_chan(res_chan),
    .res_data(res_data), .thr_hi(thr_hi), .thr_lo(thr_lo), .hyst(hyst),
    .run_limit(run_limit), .mask(mask), .act_cfg(act_cfg),
    .fault_flag(fault_flag), .fault_act(fault_act), .alarm_irq(alarm_irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one strobe at a falling edge; return at the next falling edge,
  // after the capturing rising edge, where the flag is already updated.
  task automatic send(input logic [1:0] ch, input logic [11:0] d);
    @(negedge clk);
    res_valid = 1'b1;
    res_chan  = ch;
    res_data  = d;
    @(negedge clk);
    res_valid = 1'b0;
  endtask

  task automatic t_reset();
    check("R3 flags in reset", 32'(fault_flag), 0);
    check("R3 irq in reset", 32'(alarm_irq), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R3 act after reset", 32'(fault_act), 0);
    send(2'd0, 12'hFFF);
    send(2'd0, 12'h000);
    send(2'd2, 12'hFFF);
    check("R3 default window never trips", 32'(fault_flag), 0);
  endtask

  task automatic t_high();
    thr_hi[7:0] = 8'h80;
    thr_lo[7:0] = 8'h10;
    send(2'd0, 12'h80F);
    check("R1 equal to upper limit", 32'(fault_flag), 0);
    send(2'd0, 12'h810);
    check("R1 one above upper limit", 32'(fault_flag), 3'b001);
    check("R8 action ch0", 32'(fault_act), 6'b000001);
    check("R9 irq unmasked", 32'(alarm_irq), 1);
    send(2'd0, 12'h808);
    check("R7 inside hyst band high", 32'(fault_flag), 3'b001);
    send(2'd0, 12'h807);
    check("R6 clear at hi-hyst", 32'(fault_flag), 0);
  endtask

  task automatic t_low();
    thr_lo[15:8] = 8'h20;
    send(2'd1, 12'h200);
    check("R2 equal to lower limit", 32'(fault_flag), 0);
    send(2'd1, 12'h1FF);
    check("R2 one below lower limit", 32'(fault_flag), 3'b010);
    send(2'd1, 12'h207);
    check("R7 inside hyst band low", 32'(fault_flag), 3'b010);
    send(2'd1, 12'h208);
    check("R6 clear at lo+hyst", 32'(fault_flag), 0);
  endtask

  task automatic t_count();
    thr_hi[23:16] = 8'h40;
    run_limit = 3'd3;
    for (int k = 0; k < 3; k++) send(2'd2, 12'h500);
    check("R4 three of four violations", 32'(fault_flag), 0);
    send(2'd2, 12'h300);
    check("R5 in-window resets run", 32'(fault_flag), 0);
    send(2'd2, 12'h500);
    send(2'd0, 12'h100);
    send(2'd2, 12'h500);
    send(2'd2, 12'h500);
    check("R5 run restarted after reset", 32'(fault_flag), 0);
    send(2'd2, 12'h500);
    check("R4 trips on fourth, R5 other channel ignored", 32'(fault_flag), 3'b100);
  endtask

  task automatic t_mask();
    @(negedge clk);
    check("R8 action ch2 high-z", 32'(fault_act), 6'b110000);
    check("R9 irq ch2", 32'(alarm_irq), 1);
    mask = 3'b100;
    #1;
    check("R9 masked irq", 32'(alarm_irq), 0);
    check("R9 flag kept under mask", 32'(fault_flag), 3'b100);
    check("R8 masked action", 32'(fault_act), 0);
    mask = 3'b000;
  endtask

  task automatic t_badchan();
    run_limit = 3'd0;
    send(2'd3, 12'hFFF);
    send(2'd3, 12'h000);
    check("R10 channel 3 ignored", 32'(fault_flag), 3'b100);
  endtask

  task automatic t_wrap();
    thr_hi[7:0] = 8'h00;
    thr_lo[7:0] = 8'h00;
    hyst = 7'h7F;
    send(2'd0, 12'h010);
    check("R1 tiny window trips", 32'(fault_flag), 3'b101);
    send(2'd0, 12'h000);
    check("R6 no wrap of hi-hyst", 32'(fault_flag), 3'b101);
    hyst = 7'h00;
    send(2'd0, 12'h00F);
    check("R6 zero hyst clears at limit", 32'(fault_flag), 3'b100);
  endtask

  initial begin
    rst_n = 1'b0; res_valid = 1'b0; res_chan = '0; res_data = '0;
    thr_hi = 24'hFFFFFF; thr_lo = 24'h000000; hyst = 7'd8;
    run_limit = 3'd0; mask = 3'b000; act_cfg = {2'd3, 2'd2, 2'd1};
    repeat (3) @(negedge clk);
    t_reset();
    t_high();
    t_low();
    t_count();
    t_mask();
    t_badchan();
    t_wrap();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R4 watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule